// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Serial Front End

This block is the serial slave front end of a four-channel, 10-bit voltage DAC. A host selects the block by pulling chip select low, then clocks in one 24-bit frame. The first byte is a command byte, and the block acts only when that byte marks the frame as a DAC write. The next 16 bits carry a control field and a 10-bit code. Each channel holds two registers. The input register keeps the latest code written to that channel. The DAC register keeps the code currently presented to the converter on a parallel output bus. Input registers move into DAC registers in three ways: the active-low load strobe, a transfer-all control value, or a control value that writes one channel and updates it at once.

All serial pins and the load strobe pass through two-flop synchronizers into the system clock domain. The serial controller is a four-state machine:
- S_IDLE waits for chip select to fall, then goes to S_SHIFT.
- S_SHIFT counts the falling serial-clock edges. The 24th edge moves it to S_FULL.
- In S_FULL, a further falling edge moves it to S_OVER.
- Every state returns to S_IDLE when chip select rises.
- A frame is applied only on the S_FULL to S_IDLE transition. Leaving S_SHIFT or S_OVER early or late applies nothing.

During the next transaction, the data-out line replays the last complete frame, most significant bit first.

The serial clock idles high. Codes are unipolar straight binary. A reset-select pin chooses whether reset loads all registers with 000h or with 3FFh.

Top module: `quad_dac_spi_front`

## Requirements
- R1: While rst_n is low, every input register and every DAC register loads 3FFh if rst_sel is high and 000h if it is low.
- R2: The bits of a frame are sampled on the falling serial-clock edges, most significant bit first, and the frame is 24 bits long. Bits [23:20] must equal 0001 for the frame to act. Bits [19:16] are don't-care. With any other value in bits [23:20], no register changes.
- R3: Control field bits [15:12] set to 00cc write code bits [9:0] into the input register of channel cc. No DAC register changes.
- R4: Control field 01cc writes the code into both the input register and the DAC register of channel cc. Bits [11:10] are ignored.
- R5: Control field 1000 copies all four input registers into their DAC registers.
- R6: While the synchronized load_n is low, every DAC register takes the value of its input register.
- R7: A frame in which chip select rises after fewer or more than 24 falling serial-clock edges changes no register.
- R8: A frame takes effect only when chip select rises after exactly 24 bits.
- R9: In each transaction, miso presents the last complete 24-bit frame, MSB first. The first bit is valid before the first falling serial-clock edge, and the line advances one bit after each rising edge. miso_oe is high only while the synchronized chip select is low.
- R10: A valid command byte with control field 1001 to 1111 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_sel | input | 1 | Reset level select: 0 gives 000h, 1 gives 3FFh |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data in |
| load_n | input | 1 | Active-low load strobe |
| miso | output | 1 | Serial readback data |
| miso_oe | output | 1 | Output enable for miso; high while selected |
| dac_code0 | output | 10 | DAC register code of channel 0 |
| dac_code1 | output | 10 | DAC register code of channel 1 |
| dac_code2 | output | 10 | DAC register code of channel 2 |
| dac_code3 | output | 10 | DAC register code of channel 3 |

## Verification
The frames cover input-only writes, write-and-update writes with bits [11:10] set, and a serial transfer-all. Because input-only writes do not move the outputs, the first two kinds are told apart at the outputs. Some frames carry varied don't-care command nibbles, a wrong command nibble, a reserved control value, and 23-bit and 25-bit frames. The bench detects each of these through a later strobe load or transfer, which exposes any input register that changed by mistake. Readback is checked by capturing miso bit by bit during a frame that the block ignores. Reset is applied with both levels of the reset-select pin, which separates the two reset values.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int FRAME_W  = 24;
    localparam int CODE_W   = 10;
    localparam int CH_N     = 4;
    localparam int CH_SEL_W = $clog2(CH_N);
    localparam logic [3:0] CMD_NIB = 4'b0001;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SHIFT,
        S_FULL,
        S_OVER
    } fsm_t;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= async_i;
            stage2 <= stage1;
        end
    end

    assign sync_o = stage2;

endmodule

// File: rtl/qdac_serial_fsm.sv
module qdac_serial_fsm
    import qdac_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          sclk_s,
    input  logic          mosi_s,
    output logic          commit_o,
    output logic [3:0]    ctrl_o,
    output logic [CW-1:0] data_o,
    output logic          miso_o,
    output logic          miso_oe_o
);

    localparam int CNT_W = $clog2(FW + 1);

    fsm_t             state;
    fsm_t             state_nxt;
    logic             cs_q;
    logic             sclk_q;
    logic [CNT_W-1:0] cnt;
    logic [FW-1:0]    rx_sr;
    logic [FW-1:0]    tx_sr;
    logic [FW-1:0]    last_frame;

    logic cs_fall;
    logic cs_rise;
    logic sclk_fall;
    logic sclk_rise;

    assign cs_fall   =  cs_q   & ~cs_n_s;
    assign cs_rise   = ~cs_q   &  cs_n_s;
    assign sclk_fall =  sclk_q & ~sclk_s;
    assign sclk_rise = ~sclk_q &  sclk_s;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (cs_fall) state_nxt = S_SHIFT;
            S_SHIFT: begin
                if (cs_rise)
                    state_nxt = S_IDLE;
                else if (sclk_fall && cnt == CNT_W'(FW - 1))
                    state_nxt = S_FULL;
            end
            S_FULL: begin
                if (cs_rise)
                    state_nxt = S_IDLE;
                else if (sclk_fall)
                    state_nxt = S_OVER;
            end
            S_OVER:  if (cs_rise) state_nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q       <= 1'b1;
            sclk_q     <= 1'b1;
            cnt        <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            last_frame <= '0;
            commit_o   <= 1'b0;
            miso_oe_o  <= 1'b0;
        end else begin
            cs_q      <= cs_n_s;
            sclk_q    <= sclk_s;
            commit_o  <= 1'b0;
            miso_oe_o <= ~cs_n_s;
            if (state == S_IDLE && cs_fall) begin
                cnt   <= '0;
                tx_sr <= last_frame;
            end
            if (state == S_SHIFT && sclk_fall && !cs_rise) begin
                rx_sr <= {rx_sr[FW-2:0], mosi_s};
                cnt   <= cnt + 1'b1;
            end
            if (state != S_IDLE && sclk_rise)
                tx_sr <= {tx_sr[FW-2:0], 1'b0};
            if (state == S_FULL && cs_rise) begin
                last_frame <= rx_sr;
                commit_o   <= (rx_sr[FW-1 -: 4] == CMD_NIB);
            end
        end
    end

    assign ctrl_o = last_frame[15:12];
    assign data_o = last_frame[CW-1:0];
    assign miso_o = tx_sr[FW-1];

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FW));

    assert_commit_after_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(cnt) == CNT_W'(FW));

    assert_abort_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && state != S_FULL) |=> !commit_o);

    assert_tx_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !cs_fall) |=> $stable(tx_sr));

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
#(
    parameter int NCH = CH_N,
    parameter int CW  = CODE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rst_sel,
    input  logic                    commit,
    input  logic [3:0]              ctrl,
    input  logic [CW-1:0]           data,
    input  logic                    load_act,
    output logic [NCH-1:0][CW-1:0]  codes
);

    localparam int SEL_W = $clog2(NCH);

    logic [NCH-1:0][CW-1:0] in_q;
    logic [NCH-1:0][CW-1:0] in_nxt;
    logic [NCH-1:0][CW-1:0] dac_q;
    logic [NCH-1:0][CW-1:0] dac_nxt;
    logic [SEL_W-1:0]       sel;
    logic                   wr_in;
    logic                   wr_both;
    logic                   xfer;

    assign sel     = ctrl[SEL_W-1:0];
    assign wr_in   = commit && ctrl[3:2] == 2'b00;
    assign wr_both = commit && ctrl[3:2] == 2'b01;
    assign xfer    = commit && ctrl == 4'b1000;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            in_nxt[i] = ((wr_in || wr_both) && sel == SEL_W'(i)) ? data : in_q[i];
            if (wr_both && sel == SEL_W'(i))
                dac_nxt[i] = data;
            else if (xfer || load_act)
                dac_nxt[i] = in_nxt[i];
            else
                dac_nxt[i] = dac_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= {(NCH*CW){rst_sel}};
            dac_q <= {(NCH*CW){rst_sel}};
        end else begin
            in_q  <= in_nxt;
            dac_q <= dac_nxt;
        end
    end

    assign codes = dac_q;

    assert_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(in_q));

    assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !load_act) |=> $stable(dac_q));

    assert_xfer_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !load_act) |=> dac_q == $past(in_q));

    assert_reserved_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ctrl[3] && ctrl != 4'b1000 && !load_act) |=> $stable(dac_q) && $stable(in_q));

endmodule

// File: rtl/quad_dac_spi_front.sv
module quad_dac_spi_front
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_sel,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              load_n,
    output logic              miso,
    output logic              miso_oe,
    output logic [CODE_W-1:0] dac_code0,
    output logic [CODE_W-1:0] dac_code1,
    output logic [CODE_W-1:0] dac_code2,
    output logic [CODE_W-1:0] dac_code3
);

    logic [3:0]                syn;
    logic                      commit;
    logic [3:0]                ctrl;
    logic [CODE_W-1:0]         data;
    logic [CH_N-1:0][CODE_W-1:0] codes;

    qdac_sync #(.W(4), .RST_VAL(4'b1111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({load_n, mosi, sclk, cs_n}),
        .sync_o  (syn)
    );

    qdac_serial_fsm #(.FW(FRAME_W), .CW(CODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (syn[0]),
        .sclk_s    (syn[1]),
        .mosi_s    (syn[2]),
        .commit_o  (commit),
        .ctrl_o    (ctrl),
        .data_o    (data),
        .miso_o    (miso),
        .miso_oe_o (miso_oe)
    );

    qdac_regbank #(.NCH(CH_N), .CW(CODE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_sel  (rst_sel),
        .commit   (commit),
        .ctrl     (ctrl),
        .data     (data),
        .load_act (~syn[3]),
        .codes    (codes)
    );

    assign dac_code0 = codes[0];
    assign dac_code1 = codes[1];
    assign dac_code2 = codes[2];
    assign dac_code3 = codes[3];

endmodule

// File: tb/quad_dac_spi_front_tb.sv
module quad_dac_spi_front_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_sel = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic mosi = 1'b0;
    logic load_n = 1'b1;
    logic miso;
    logic miso_oe;
    logic [9:0] dac_code0, dac_code1, dac_code2, dac_code3;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [23:0] cap;
    bit oe_seen_low;

    always #10 clk = ~clk;

    quad_dac_spi_front u_dut (
        .clk(clk), .rst_n(rst_n), .rst_sel(rst_sel), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .load_n(load_n), .miso(miso), .miso_oe(miso_oe),
        .dac_code0(dac_code0), .dac_code1(dac_code1),
        .dac_code2(dac_code2), .dac_code3(dac_code3)
    );

    // {load, len, frame, exp3, exp2, exp1, exp0}
    localparam int NV = 13;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0, 5'd24, 24'h100155, 10'h000, 10'h000, 10'h000, 10'h000}, // R3 ch0 input only
        {1'b0, 5'd24, 24'h1F12AA, 10'h000, 10'h000, 10'h000, 10'h000}, // R2 don't-care nibble, R3
        {1'b0, 5'd24, 24'h108000, 10'h000, 10'h000, 10'h2AA, 10'h155}, // R5 transfer all
        {1'b0, 5'd24, 24'h136FC3, 10'h000, 10'h3C3, 10'h2AA, 10'h155}, // R4 write+update, bits 11:10 set
        {1'b0, 5'd24, 24'h207111, 10'h000, 10'h3C3, 10'h2AA, 10'h155}, // R2 wrong command nibble
        {1'b0, 5'd23, 24'h107123, 10'h000, 10'h3C3, 10'h2AA, 10'h155}, // R7 short frame
        {1'b0, 5'd25, 24'h1070F0, 10'h000, 10'h3C3, 10'h2AA, 10'h155}, // R7 long frame
        {1'b0, 5'd24, 24'h1093FF, 10'h000, 10'h3C3, 10'h2AA, 10'h155}, // R10 reserved control
        {1'b0, 5'd24, 24'h1030AB, 10'h000, 10'h3C3, 10'h2AA, 10'h155}, // R3 ch3 input only
        {1'b1, 5'd0,  24'h000000, 10'h0AB, 10'h3C3, 10'h2AA, 10'h155}, // R6 strobe load
        {1'b0, 5'd24, 24'h1043FF, 10'h0AB, 10'h3C3, 10'h2AA, 10'h3FF}, // R4 ch0 update
        {1'b0, 5'd24, 24'h100001, 10'h0AB, 10'h3C3, 10'h2AA, 10'h3FF}, // R3 no DAC change
        {1'b0, 5'd24, 24'h108000, 10'h0AB, 10'h3C3, 10'h2AA, 10'h001}  // R5 R8 transfer
    };

    function automatic string tag_of(int i);
        case (i)
            0, 8, 11: return "R3";
            1, 4:     return "R2";
            2, 12:    return "R5";
            3, 10:    return "R4";
            5, 6:     return "R7";
            7:        return "R10";
            9:        return "R6";
            default:  return "R8";
        endcase
    endfunction

    task automatic check_codes(string tag, logic [39:0] exp);
        logic [39:0] act;
        act = {dac_code3, dac_code2, dac_code1, dac_code0};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s codes act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic send_frame(logic [23:0] frame, int len);
        @(negedge clk);
        cs_n = 1'b0;
        oe_seen_low = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < len; b++) begin
            if (b < 24) cap[23-b] = miso;
            if (!miso_oe) oe_seen_low = 1'b1;
            mosi = (b < 24) ? frame[23-b] : 1'b0;
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load_n = 1'b0;
        repeat (6) @(negedge clk);
        load_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset(logic sel);
        @(negedge clk);
        rst_sel = sel;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        do_reset(1'b0);
        check_codes("R1 reset low", 40'h0);
        check_bit("R9 oe idle", miso_oe, 1'b0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][69]) pulse_load();
            else send_frame(VEC[i][63:40], int'(VEC[i][68:64]));
            check_codes(tag_of(i), VEC[i][39:0]);
        end

        // R9 readback of last complete frame
        send_frame(24'h1041A5, 24);
        check_codes("R4 readback setup", {10'h0AB, 10'h3C3, 10'h2AA, 10'h1A5});
        send_frame(24'h000000, 24);
        checks++;
        if (cap !== 24'h1041A5) begin
            fails++;
            $display("FAIL R9 readback act=%h exp=%h", cap, 24'h1041A5);
        end
        check_bit("R9 oe during frame", oe_seen_low, 1'b0);
        check_bit("R9 oe after frame", miso_oe, 1'b0);
        check_codes("R2 zero command", {10'h0AB, 10'h3C3, 10'h2AA, 10'h1A5});

        // R1 reset high, input registers also reset high
        do_reset(1'b1);
        check_codes("R1 reset high", {4{10'h3FF}});
        send_frame(24'h100000, 24);
        send_frame(24'h108000, 24);
        check_codes("R1 input regs high", {10'h3FF, 10'h3FF, 10'h3FF, 10'h000});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule